// File: doc/BRIEF.md
# Console serial port register block

This block is the register face of a 16550-compatible serial port, cut down to what an operating-system console driver touches. A host reaches eight byte-wide registers through a simple single-cycle bus. Bytes written to the data port leave at once on a byte-stream output, because there is no serial shifter. Bytes arriving on a byte-stream input with a valid/ready handshake are held in a receive queue until the host reads them. One level interrupt output reports receive data and transmitter-idle conditions.

Registers can be spread apart in the address space by a configurable shift, and every access must use one fixed size. A loopback mode routes data-port writes back into the receive queue instead of the output stream. The reset is synchronous and active high. Read data and the error flag are registered and appear in the cycle after the request.

Top module: `serial_console_regs`

## Requirements
- R1: The register index is (bus_addr >> REG_SHIFT) modulo 8, so address bits below the shift and above the index are ignored. A request whose bus_size differs from REG_IO_WIDTH gives bus_err = 1 in the next cycle, returns 0 and changes no register.
- R2: After reset the registers read as follows: index 1 reads 0x00, index 2 reads 0xC1, index 3 reads 0x00, index 4 reads 0x08, index 5 reads 0x60, index 6 reads 0xB0 and index 7 reads 0x00. With the divisor select bit set, the divisor bytes read 0x0C (low) and 0x00 (high).
- R3: While bit 7 of the line control register (index 3) is set, index 0 reads and writes the low divisor byte and index 1 reads and writes the high divisor byte. While bit 7 is clear, index 0 is the data port and index 1 is the interrupt enable register.
- R4: A write to the interrupt enable register stores only bits 3:0. Bits 7:4 read as zero.
- R5: In normal mode, a data-port write presents the byte on tx_data with tx_valid high for exactly the following cycle. Bits 6 and 5 of the line status register (index 5) always read 1, and bits 7 and 4:1 read 0.
- R6: While bit 4 of the modem control register (index 4) is set, a data-port write emits nothing. The byte is appended to the receive queue if the queue holds fewer than RX_DEPTH bytes, and is dropped otherwise.
- R7: rx_ready is high exactly when bit 0 of the last write to index 2 was 1, loopback is off, and the queue holds fewer than RX_DEPTH bytes. A byte is taken when rx_valid and rx_ready are both high at a clock edge. Line status bit 0 reads 1 exactly when the queue is not empty.
- R8: A data-port read returns and removes the oldest queued byte, so bytes come out in arrival order. A data-port read on an empty queue returns 0.
- R9: A write to index 2 with bit 1 set empties the receive queue. This also discards a stream byte taken in the same cycle. Bits 1 and 2 are not stored.
- R10: The identification code is 0x04 when interrupt enable bit 0 is set and the queue is not empty. Otherwise it is 0x02 when enable bit 1 is set, and otherwise 0x01. Index 2 reads the code ORed with 0xC0. irq is high exactly when the code is not 0x01. Both the code and irq follow the state with one clock of delay.
- R11: Writes to index 5 and index 6 have no effect. Index 7 reads back the last byte written to it.
- R12: bus_rdata carries the read value in the cycle after a read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the block |
| bus_size | input | SIZE_W | Access size in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, the cycle after the request |
| bus_err | output | 1 | Size mismatch flag, the cycle after the request |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present for one cycle |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong queue count or pointer first shows on rx_ready and on line status bit 0. A wrong count or pointer also shows on the next data-port read, which returns a byte out of order or a stale byte instead of 0. A wrongly stored enable bit or a wrong priority shows on irq one clock after the write that causes it. The same fault shows on the identification value at the next read of index 2. A misrouted decode, such as divisor select or loopback, shows in the cycle after the access: a byte appears on tx_data when it should not, or fails to appear when it should. Because the reference model is compared with every output on every clock, each of these faults is caught in the first cycle it reaches a port.

// File: rtl/scon_pkg.sv
package scon_pkg;

  typedef enum logic [2:0] {
    IDX_DATA = 3'd0,
    IDX_IEN  = 3'd1,
    IDX_IDFC = 3'd2,
    IDX_LCTL = 3'd3,
    IDX_MCTL = 3'd4,
    IDX_LSTS = 3'd5,
    IDX_MSTS = 3'd6,
    IDX_SCR  = 3'd7
  } reg_idx_e;

  localparam int BYTE_W = 8;

  localparam logic [7:0] DIVLO_RST = 8'h0C;
  localparam logic [7:0] MCTL_RST  = 8'h08;
  localparam logic [7:0] MSTS_VAL  = 8'hB0;
  localparam logic [7:0] IID_TYPE  = 8'hC0;

  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_RXD  = 4'h4;
  localparam logic [3:0] CODE_TXE  = 4'h2;

  localparam int LCTL_DLAB  = 7;
  localparam int MCTL_LOOP  = 4;
  localparam int FCTL_EN    = 0;
  localparam int FCTL_RXCLR = 1;
  localparam int IEN_RX     = 0;
  localparam int IEN_TX     = 1;

endpackage

// File: rtl/scon_rx_fifo.sv
module scon_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          has_data;
  logic          has_room;
  logic          do_push;
  logic          do_pop;

  assign has_data = (count != '0);
  assign has_room = (count < CW'(DEPTH));
  assign do_push  = push && has_room && !flush;
  assign do_pop   = pop && has_data;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // registered read port; an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst)      pop_data <= '0;
    else if (pop) pop_data <= has_data ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/scon_ctrl_regs.sv
module scon_ctrl_regs
  import scon_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic        we,
  input  reg_idx_e    idx,
  input  logic [7:0]  wdata,
  input  logic        rx_avail,
  input  logic [3:0]  iid_code,
  output logic [3:0]  ier,
  output logic        fifo_en,
  output logic        loop_on,
  output logic [7:0]  lctl,
  output logic        emit,
  output logic        lb_push,
  output logic        pop,
  output logic        flush,
  output logic [7:0]  rd_val_q,
  output logic        rd_fifo_q
);

  logic [7:0] div_lo;
  logic [7:0] div_hi;
  logic [3:0] ier_q;
  logic       fen_q;
  logic [7:0] lctl_q;
  logic [7:0] mctl_q;
  logic [7:0] scr_q;
  logic       dlab;
  logic       data_sel;
  logic [7:0] rd_val;

  assign dlab     = lctl_q[LCTL_DLAB];
  assign data_sel = acc && (idx == IDX_DATA) && !dlab;
  assign pop      = data_sel && !we;
  assign emit     = data_sel && we && !mctl_q[MCTL_LOOP];
  assign lb_push  = data_sel && we && mctl_q[MCTL_LOOP];
  assign flush    = acc && we && (idx == IDX_IDFC) && wdata[FCTL_RXCLR];

  assign ier     = ier_q;
  assign fifo_en = fen_q;
  assign loop_on = mctl_q[MCTL_LOOP];
  assign lctl    = lctl_q;

  always_comb begin
    rd_val = '0;
    unique case (idx)
      IDX_DATA: rd_val = div_lo;
      IDX_IEN:  rd_val = dlab ? div_hi : {4'b0000, ier_q};
      IDX_IDFC: rd_val = IID_TYPE | {4'b0000, iid_code};
      IDX_LCTL: rd_val = lctl_q;
      IDX_MCTL: rd_val = mctl_q;
      IDX_LSTS: rd_val = {1'b0, 2'b11, 4'b0000, rx_avail};
      IDX_MSTS: rd_val = MSTS_VAL;
      IDX_SCR:  rd_val = scr_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= DIVLO_RST;
      div_hi <= '0;
      ier_q  <= '0;
      fen_q  <= 1'b0;
      lctl_q <= '0;
      mctl_q <= MCTL_RST;
      scr_q  <= '0;
    end else if (acc && we) begin
      unique case (idx)
        IDX_DATA: if (dlab) div_lo <= wdata;
        IDX_IEN: begin
          if (dlab) div_hi <= wdata;
          else      ier_q  <= wdata[3:0];
        end
        IDX_IDFC: fen_q  <= wdata[FCTL_EN];
        IDX_LCTL: lctl_q <= wdata;
        IDX_MCTL: mctl_q <= wdata;
        IDX_SCR:  scr_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val_q  <= '0;
      rd_fifo_q <= 1'b0;
    end else begin
      rd_val_q  <= (acc && !we && !data_sel) ? rd_val : '0;
      rd_fifo_q <= pop;
    end
  end

endmodule

// File: rtl/scon_irq_gen.sv
module scon_irq_gen
  import scon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ier,
  input  logic       rx_avail,
  output logic       irq,
  output logic [3:0] iid_code
);

  logic rx_pend;
  logic tx_pend;

  assign rx_pend = ier[IEN_RX] && rx_avail;
  // the transmitter never holds a byte, so its idle status is always set
  assign tx_pend = ier[IEN_TX];

  always_ff @(posedge clk) begin
    if (rst) begin
      iid_code <= CODE_NONE;
      irq      <= 1'b0;
    end else begin
      if (rx_pend)      iid_code <= CODE_RXD;
      else if (tx_pend) iid_code <= CODE_TXE;
      else              iid_code <= CODE_NONE;
      irq <= rx_pend || tx_pend;
    end
  end

endmodule

// File: rtl/serial_console_regs.sv
module serial_console_regs
  import scon_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SIZE_W       = 3,
  parameter int REG_SHIFT    = 0,
  parameter int REG_IO_WIDTH = 1,
  parameter int RX_DEPTH     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              irq
);

  localparam int CNT_W = $clog2(RX_DEPTH) + 1;

  logic             size_ok;
  logic             acc;
  reg_idx_e         idx;
  logic [3:0]       ier;
  logic             fifo_en;
  logic             loop_on;
  logic [7:0]       lctl_val;
  logic             emit;
  logic             lb_push;
  logic             pop;
  logic             flush;
  logic [7:0]       rd_val_q;
  logic             rd_fifo_q;
  logic [7:0]       pop_data;
  logic [CNT_W-1:0] q_count;
  logic             rx_avail;
  logic             room;
  logic             push;
  logic [7:0]       push_data;
  logic [3:0]       iid_code;

  assign size_ok = (bus_size == SIZE_W'(REG_IO_WIDTH));
  assign acc     = bus_req && size_ok;
  assign idx     = reg_idx_e'(3'(bus_addr >> REG_SHIFT));

  assign rx_avail  = (q_count != '0);
  assign room      = (q_count < CNT_W'(RX_DEPTH));
  assign rx_ready  = fifo_en && !loop_on && room;
  assign push      = (rx_valid && rx_ready) || (lb_push && room);
  assign push_data = lb_push ? bus_wdata : rx_data;

  scon_ctrl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .we        (bus_we),
    .idx       (idx),
    .wdata     (bus_wdata),
    .rx_avail  (rx_avail),
    .iid_code  (iid_code),
    .ier       (ier),
    .fifo_en   (fifo_en),
    .loop_on   (loop_on),
    .lctl      (lctl_val),
    .emit      (emit),
    .lb_push   (lb_push),
    .pop       (pop),
    .flush     (flush),
    .rd_val_q  (rd_val_q),
    .rd_fifo_q (rd_fifo_q)
  );

  scon_rx_fifo #(
    .DEPTH (RX_DEPTH),
    .DW    (BYTE_W)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .count     (q_count)
  );

  scon_irq_gen u_irq (
    .clk      (clk),
    .rst      (rst),
    .ier      (ier),
    .rx_avail (rx_avail),
    .irq      (irq),
    .iid_code (iid_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_err  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      bus_err  <= bus_req && !size_ok;
      tx_valid <= emit;
      if (emit) tx_data <= bus_wdata;
    end
  end

  assign bus_rdata = rd_fifo_q ? pop_data : rd_val_q;

endmodule

// File: rtl/scon_chk.sv
module scon_chk #(
  parameter int SIZE_W = 3,
  parameter int IO_W   = 1,
  parameter int DEPTH  = 64,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [SIZE_W-1:0] bus_size,
  input logic              bus_err,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [3:0]        iid_code,
  input logic [CW-1:0]     q_count,
  input logic              loop_on,
  input logic [7:0]        lctl
);

  // R1
  size_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_size != SIZE_W'(IO_W)) |=> bus_err);

  // R1
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_size != SIZE_W'(IO_W)) |=> $stable(lctl));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (q_count == CW'(DEPTH)) |-> !rx_ready);

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  // R6
  loop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> !tx_valid);

  // R5
  tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_req && bus_we));

  // R10
  irq_code_hi_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (iid_code != 4'h1));

  // R10
  irq_code_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (iid_code == 4'h1));

endmodule

bind serial_console_regs scon_chk #(
  .SIZE_W (SIZE_W),
  .IO_W   (REG_IO_WIDTH),
  .DEPTH  (RX_DEPTH),
  .CW     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_size (bus_size),
  .bus_err  (bus_err),
  .tx_valid (tx_valid),
  .rx_ready (rx_ready),
  .irq      (irq),
  .iid_code (iid_code),
  .q_count  (q_count),
  .loop_on  (loop_on),
  .lctl     (lctl_val)
);

// File: tb/sim_serial_console_regs.sv
module sim_serial_console_regs;

  localparam int CLK_P = 10;
  localparam int SH    = 2;
  localparam int IOW   = 4;
  localparam int AW    = 8;
  localparam int SW    = 3;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [SW-1:0] bus_size = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_err;
  logic [7:0]    rx_data = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          irq;

  serial_console_regs #(
    .ADDR_W(AW), .SIZE_W(SW), .REG_SHIFT(SH), .REG_IO_WIDTH(IOW), .RX_DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] mq[$];
  logic [7:0] m_dll = 8'h0C, m_dlm = 0, m_lcr = 0, m_mcr = 8'h08, m_scr = 0;
  logic [3:0] m_ier = 0, m_code = 4'h1, n_code;
  logic       m_fen = 0, m_irq = 0;
  logic       e_err = 0, e_txv = 0, e_rdy = 0, rdy_old, flushed;
  logic [7:0] e_rd = 0, e_txd = 0;
  logic [2:0] ix;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_dll = 8'h0C; m_dlm = 0; m_ier = 0; m_fen = 0; m_lcr = 0;
      m_mcr = 8'h08; m_scr = 0; m_code = 4'h1; m_irq = 0;
      e_err = 0; e_rd = 0; e_txv = 0;
    end else begin
      n_code  = (m_ier[0] && mq.size() != 0) ? 4'h4 : (m_ier[1] ? 4'h2 : 4'h1);
      rdy_old = m_fen && !m_mcr[4] && (mq.size() < DEPTH);
      e_err = 0; e_rd = 0; e_txv = 0; flushed = 0;
      if (bus_req) begin
        if (bus_size != SW'(IOW)) e_err = 1;
        else begin
          ix = 3'(bus_addr >> SH);
          if (!bus_we) begin
            case (ix)
              0: if (m_lcr[7]) e_rd = m_dll;
                 else if (mq.size() != 0) e_rd = mq.pop_front();
              1: e_rd = m_lcr[7] ? m_dlm : {4'h0, m_ier};
              2: e_rd = 8'hC0 | {4'h0, m_code};
              3: e_rd = m_lcr;
              4: e_rd = m_mcr;
              5: e_rd = (mq.size() != 0) ? 8'h61 : 8'h60;
              6: e_rd = 8'hB0;
              default: e_rd = m_scr;
            endcase
          end else begin
            case (ix)
              0: if (m_lcr[7]) m_dll = bus_wdata;
                 else if (m_mcr[4]) begin
                   if (mq.size() < DEPTH) mq.push_back(bus_wdata);
                 end else begin
                   e_txv = 1; e_txd = bus_wdata;
                 end
              1: if (m_lcr[7]) m_dlm = bus_wdata; else m_ier = bus_wdata[3:0];
              2: begin
                   m_fen = bus_wdata[0];
                   if (bus_wdata[1]) begin mq.delete(); flushed = 1; end
                 end
              3: m_lcr = bus_wdata;
              4: m_mcr = bus_wdata;
              7: m_scr = bus_wdata;
              default: ;
            endcase
          end
        end
      end
      if (rx_valid && rdy_old && !flushed) mq.push_back(rx_data);
      m_code = n_code;
      m_irq  = (n_code != 4'h1);
    end
    e_rdy = m_fen && !m_mcr[4] && (mq.size() < DEPTH);
  end

  // every-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    chk(bus_err === e_err, "R1 bus_err", int'(bus_err), int'(e_err));
    chk(bus_rdata === e_rd, "R12 bus_rdata", int'(bus_rdata), int'(e_rd));
    chk(tx_valid === e_txv, "R5 tx_valid", int'(tx_valid), int'(e_txv));
    if (e_txv) chk(tx_data === e_txd, "R5 tx_data", int'(tx_data), int'(e_txd));
    chk(irq === m_irq, "R10 irq", int'(irq), int'(m_irq));
    chk(rx_ready === e_rdy, "R7 rx_ready", int'(rx_ready), int'(e_rdy));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [AW-1:0] ad(input int i);
    return AW'(i << SH);
  endfunction

  logic [7:0] r_rd, r_td;
  logic       r_err, r_tv;

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [7:0] d, input logic [SW-1:0] sz);
    @(negedge clk);
    bus_req = 1; bus_we = w; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk); #(CLK_P/4);
    r_rd = bus_rdata; r_err = bus_err; r_tv = tx_valid; r_td = tx_data;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(input int i, input logic [7:0] d);
    acc(1'b1, ad(i), d, SW'(IOW));
  endtask

  task automatic rd_chk(input int i, input logic [7:0] exp, input string tag);
    acc(1'b0, ad(i), 8'h00, SW'(IOW));
    chk(r_rd === exp, tag, int'(r_rd), int'(exp));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); @(posedge clk); #(CLK_P/4);
    end
  endtask

  task automatic stream_one(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(posedge clk); #(CLK_P/4); rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4); rst = 0;
    chk(rx_ready === 1'b0, "R7 ready low after reset", int'(rx_ready), 0);
    chk(irq === 1'b0, "R10 irq low after reset", int'(irq), 0);

    // R2 reset values
    rd_chk(1, 8'h00, "R2 ier reset");
    rd_chk(2, 8'hC1, "R2 iid reset");
    rd_chk(3, 8'h00, "R2 lctl reset");
    rd_chk(4, 8'h08, "R2 mctl reset");
    rd_chk(5, 8'h60, "R2 lsts reset");
    rd_chk(6, 8'hB0, "R2 msts reset");
    rd_chk(7, 8'h00, "R2 scr reset");
    rd_chk(0, 8'h00, "R8 empty read");
    wr(3, 8'h80);
    rd_chk(0, 8'h0C, "R2 div lo reset");
    rd_chk(1, 8'h00, "R2 div hi reset");

    // R3 divisor select
    wr(0, 8'h34);
    chk(r_tv === 1'b0, "R3 divisor write not emitted", int'(r_tv), 0);
    wr(1, 8'h12);
    rd_chk(0, 8'h34, "R3 div lo");
    rd_chk(1, 8'h12, "R3 div hi");
    wr(3, 8'h03);
    rd_chk(1, 8'h00, "R3 ier untouched by divisor");
    rd_chk(3, 8'h03, "R3 lctl readback");

    // R4 enable mask, R10 transmit interrupt
    wr(1, 8'hFF);
    rd_chk(1, 8'h0F, "R4 ier mask");
    idle(1);
    chk(irq === 1'b1, "R10 irq tx pending", int'(irq), 1);
    rd_chk(2, 8'hC2, "R10 iid tx");
    wr(1, 8'h00);
    idle(1);
    chk(irq === 1'b0, "R10 irq cleared", int'(irq), 0);
    rd_chk(2, 8'hC1, "R10 iid none");

    // R11 scratch and read-only status
    wr(7, 8'hA5);
    rd_chk(7, 8'hA5, "R11 scratch");
    wr(5, 8'h00);
    wr(6, 8'h00);
    rd_chk(5, 8'h60, "R11 lsts write ignored");
    rd_chk(6, 8'hB0, "R11 msts write ignored");

    // R1 size check and address folding
    acc(1'b1, ad(7), 8'h11, SW'(1));
    chk(r_err === 1'b1, "R1 size error", int'(r_err), 1);
    rd_chk(7, 8'hA5, "R1 rejected write left scratch");
    acc(1'b0, ad(7), 8'h00, SW'(2));
    chk(r_err === 1'b1 && r_rd === 8'h00, "R1 rejected read", int'(r_rd), 0);
    acc(1'b0, AW'((15 << SH) | 1), 8'h00, SW'(IOW));
    chk(r_rd === 8'hA5, "R1 index folding", int'(r_rd), 8'hA5);

    // R5 transmit
    wr(0, 8'h41);
    chk(r_tv === 1'b1 && r_td === 8'h41, "R5 tx byte", int'(r_td), 8'h41);
    idle(1);
    chk(tx_valid === 1'b0, "R5 tx single cycle", int'(tx_valid), 0);
    rd_chk(5, 8'h60, "R5 lsts after tx");

    // R6 loopback
    wr(4, 8'h18);
    wr(0, 8'h55);
    chk(r_tv === 1'b0, "R6 no emit in loopback", int'(r_tv), 0);
    wr(0, 8'h66);
    rd_chk(5, 8'h61, "R6 data ready");
    rd_chk(0, 8'h55, "R8 first");
    rd_chk(0, 8'h66, "R8 second");
    rd_chk(5, 8'h60, "R8 drained");
    rd_chk(0, 8'h00, "R8 empty after drain");
    for (int i = 0; i <= DEPTH; i++) wr(0, 8'(i + 1));
    rd_chk(5, 8'h61, "R6 full queue");
    for (int i = 0; i < DEPTH; i++) rd_chk(0, 8'(i + 1), "R6 queue order at capacity");
    rd_chk(0, 8'h00, "R6 overflow byte dropped");

    // R7 stream intake
    wr(4, 8'h08);
    chk(rx_ready === 1'b0, "R7 gated by enable", int'(rx_ready), 0);
    wr(2, 8'h01);
    chk(rx_ready === 1'b1, "R7 ready", int'(rx_ready), 1);
    stream_one(8'h10);
    stream_one(8'h20);
    stream_one(8'h30);
    rd_chk(5, 8'h61, "R7 data ready");
    wr(1, 8'h01);
    idle(1);
    rd_chk(2, 8'hC4, "R10 iid rx");
    wr(1, 8'h03);
    idle(1);
    rd_chk(2, 8'hC4, "R10 rx priority");
    rd_chk(0, 8'h10, "R8 stream order 1");
    rd_chk(0, 8'h20, "R8 stream order 2");
    rd_chk(0, 8'h30, "R8 stream order 3");
    idle(1);
    rd_chk(2, 8'hC2, "R10 falls back to tx");
    wr(1, 8'h00);

    // R9 flush
    stream_one(8'h77);
    stream_one(8'h88);
    wr(2, 8'h07);
    rd_chk(5, 8'h60, "R9 flushed");
    rd_chk(0, 8'h00, "R9 empty after flush");
    // flush in the same cycle as a stream byte
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h99;
    bus_req = 1; bus_we = 1; bus_addr = ad(2); bus_wdata = 8'h03; bus_size = SW'(IOW);
    @(posedge clk); #(CLK_P/4);
    rx_valid = 0; bus_req = 0; bus_we = 0;
    rd_chk(5, 8'h60, "R9 same-cycle byte discarded");

    // R7 disabled intake
    wr(2, 8'h00);
    @(negedge clk); rx_valid = 1; rx_data = 8'hEE;
    repeat (3) @(negedge clk);
    rx_valid = 0;
    rd_chk(5, 8'h60, "R7 no intake when disabled");

    // R7 fill from stream
    wr(2, 8'h01);
    for (int i = 0; i < DEPTH + 6; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(8'h80 + i);
    end
    @(negedge clk); rx_valid = 0;
    @(posedge clk); #(CLK_P/4);
    chk(rx_ready === 1'b0, "R7 ready low when full", int'(rx_ready), 0);
    rd_chk(0, 8'h80, "R8 head after fill");
    chk(rx_ready === 1'b1, "R7 ready after pop", int'(rx_ready), 1);
    wr(4, 8'h18);
    chk(rx_ready === 1'b0, "R6 ready low in loopback", int'(rx_ready), 0);
    wr(4, 8'h08);
    wr(2, 8'h03);
    rd_chk(5, 8'h60, "R9 flush full queue");
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule